// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block arbitrates the interrupt sources of a small 8-bit control core. It handles one non-maskable watchdog request, eight maskable sources and a software break. Each maskable source has a request flag. Software supplies a mask bit and a priority-group bit for each maskable source. Three of the maskable sources come from asynchronous external pins through synchronizing edge detectors. The other five are single-cycle event pulses from on-chip peripherals: the watchdog in interval mode, serial end, timer 1 match, timer 2 match and conversion end.

Each cycle the block picks one winner. The non-maskable request wins over the break, and the break wins over the maskable sources. Among the maskable sources the high group wins over the low group, and a fixed default order breaks ties inside a group. The block offers the CPU a vector address, a kind code and a valid strobe, and it holds the offer until the CPU acknowledges it.

On acknowledge the block updates its state. It clears the accepted request, clears the global enable and records the priority group of the handler now in service. A separate wake output tells the standby controller that an unmasked request is pending, whether or not that request can be accepted yet.

Top module: `irq_arbiter`

## Requirements
- R1: After reset no request flag is set, the global enable is clear, no high-group handler is in service, `irq_valid` and `wake` are 0, `irq_vector` is 0000h and `irq_kind` is 3 (none).
- R2: The vector addresses are fixed. Non-maskable is 0004h and break is 003Eh. The maskable sources, by index, are: 0 watchdog-interval at 0004h, 1 pin 1 at 0008h, 2 pin 2 at 000Ah, 3 pin 3 at 000Ch, 4 serial at 0010h, 5 timer 1 at 0016h, 6 timer 2 at 0018h and 7 conversion end at 001Ah. `irq_kind` is 0 for maskable, 1 for non-maskable and 2 for break. Flag index 0 comes from `wdt_evt` and indices 4 to 7 come from `periph_evt[0]` to `periph_evt[3]`.
- R3: Among pending unmasked requests of the same group, the lowest index wins.
- R4: A request whose `prio_bits` bit is 1 (high group) wins over every low-group request, whatever their indices.
- R5: A maskable request is offered only when the global enable is set and no high-group handler is in service. A `mask_bits` bit of 1 blocks its source.
- R6: When `irq_valid` and `irq_ack` are both high at a clock edge, the block clears the accepted request flag and the global enable, and marks a high-group handler in service if the accepted source was high group. The acknowledge wins over `ie_set` in the same cycle.
- R7: A non-maskable request is offered regardless of the global enable and the masks, and it outranks everything else. After its acknowledge it is not offered again until `nmi_ret` pulses. A request that arrives in the meantime is kept.
- R8: A break request (`brk_req`) is offered regardless of the global enable. It ranks below non-maskable and above all maskable requests.
- R9: Each pin passes through two synchronizer stages. Its request flag is set at the third rising clock edge after the pin changes. Pin modes for pins 1 and 2 are encoded as 00 off, 01 rising, 10 falling and 11 both. Pin 3 detects falling edges only.
- R10: A request flag stays set until it is acknowledged or cleared through `req_clr`. A new event in the same cycle as a clear or acknowledge of that flag leaves the flag set.
- R11: `wake` is 1 whenever an unmasked maskable flag or a non-maskable request is pending, independent of the global enable and the in-service state.
- R12: A `reti` pulse ends the high-group in-service state, so that pending maskable requests can be offered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wdt_evt | input | 1 | Watchdog interval event pulse (maskable index 0) |
| periph_evt | input | 4 | Serial, timer 1, timer 2, conversion-end event pulses |
| nmi_evt | input | 1 | Non-maskable watchdog request pulse |
| brk_req | input | 1 | Software break request pulse |
| pin_in | input | 3 | Asynchronous external interrupt pins 1 to 3 |
| pin1_mode | input | 2 | Edge mode of pin 1 |
| pin2_mode | input | 2 | Edge mode of pin 2 |
| mask_bits | input | 8 | Per-source mask, 1 blocks |
| prio_bits | input | 8 | Per-source group, 1 is high group |
| req_clr | input | 8 | Software clear pulses for the request flags |
| ie_set | input | 1 | Sets the global enable |
| reti | input | 1 | Return from a maskable handler |
| nmi_ret | input | 1 | Return from the non-maskable handler |
| irq_ack | input | 1 | CPU accepts the offered interrupt |
| irq_valid | output | 1 | An interrupt is offered |
| irq_vector | output | 16 | Vector address of the offer |
| irq_kind | output | 2 | 0 maskable, 1 non-maskable, 2 break, 3 none |
| irq_idx | output | 3 | Maskable source index of the offer |
| wake | output | 1 | Standby release |

## Verification
Two functions can fall into the same clock edge on one source: the acknowledge or software clear that removes a request flag, and a fresh event that sets the same flag. The bench provokes this by driving the event pulse together with `irq_ack`, or with the matching `req_clr` bit, in a single step. It judges the result at the ports. `irq_valid` must drop because the global enable is gone, while `wake` must stay high, and the same vector must be offered again as soon as the enable is restored. A second collision, a non-maskable and a break request raised together, is judged by the order in which the two vectors appear.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int unsigned NUM_MSK    = 8;
  localparam int unsigned IDX_W      = $clog2(NUM_MSK);
  localparam int unsigned NUM_PIN    = 3;
  localparam int unsigned NUM_PERIPH = 4;
  localparam int unsigned VEC_W      = 16;

  localparam logic [VEC_W-1:0] NMI_VEC = 16'h0004;
  localparam logic [VEC_W-1:0] BRK_VEC = 16'h003E;

  typedef enum logic [1:0] {
    KIND_MSK  = 2'd0,
    KIND_NMI  = 2'd1,
    KIND_BRK  = 2'd2,
    KIND_NONE = 2'd3
  } irq_kind_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;

  // fixed vector of each maskable source, indexed by default order
  function automatic logic [VEC_W-1:0] msk_vector(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    msk_vector = 16'h0004;
      3'd1:    msk_vector = 16'h0008;
      3'd2:    msk_vector = 16'h000A;
      3'd3:    msk_vector = 16'h000C;
      3'd4:    msk_vector = 16'h0010;
      3'd5:    msk_vector = 16'h0016;
      3'd6:    msk_vector = 16'h0018;
      default: msk_vector = 16'h001A;
    endcase
  endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det
  import irq_arb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] mode,
  output logic       edge_pulse
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall = ~sync_q[SYNC_STAGES-1] & prev_q;

  always_comb begin
    unique case (edge_mode_e'(mode))
      EDGE_RISE: edge_pulse = rise;
      EDGE_FALL: edge_pulse = fall;
      EDGE_BOTH: edge_pulse = rise | fall;
      default:   edge_pulse = 1'b0;
    endcase
  end

  // R9: a detected edge always means the synchronized level just moved
  a_r9_edge_is_change: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |-> (sync_q[SYNC_STAGES-1] != $past(sync_q[SYNC_STAGES-1])));

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] sw_clr_i,
  input  logic [N-1:0] ack_clr_i,
  output logic [N-1:0] req_o
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)                          req_o[i] <= 1'b0;
      else if (set_i[i])                   req_o[i] <= 1'b1;
      else if (sw_clr_i[i] | ack_clr_i[i]) req_o[i] <= 1'b0;
    end

    // R10: a new event is never lost to a same-cycle clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> req_o[i]);

    // R10: with no event and no clear, a pending flag holds
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o[i] && !sw_clr_i[i] && !ack_clr_i[i]) |=> req_o[i]);
  end

  // R6: an acknowledge clears at most one flag
  a_r6_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_clr_i));

endmodule

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  input  logic [N-1:0]     mask,
  input  logic [N-1:0]     prio,
  output logic             hit,
  output logic             grp_high,
  output logic [IDX_W-1:0] idx
);

  logic [N-1:0] pend, pend_hi;

  // lowest set index: the default order
  function automatic logic [IDX_W-1:0] lowest(input logic [N-1:0] v);
    lowest = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) lowest = IDX_W'(i);
    end
  endfunction

  assign pend     = req & ~mask;
  assign pend_hi  = pend & prio;
  assign hit      = |pend;
  assign grp_high = |pend_hi;
  assign idx      = grp_high ? lowest(pend_hi) : lowest(pend);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wdt_evt,
  input  logic [NUM_PERIPH-1:0] periph_evt,
  input  logic                  nmi_evt,
  input  logic                  brk_req,
  input  logic [NUM_PIN-1:0]    pin_in,
  input  logic [1:0]            pin1_mode,
  input  logic [1:0]            pin2_mode,
  input  logic [NUM_MSK-1:0]    mask_bits,
  input  logic [NUM_MSK-1:0]    prio_bits,
  input  logic [NUM_MSK-1:0]    req_clr,
  input  logic                  ie_set,
  input  logic                  reti,
  input  logic                  nmi_ret,
  input  logic                  irq_ack,
  output logic                  irq_valid,
  output logic [VEC_W-1:0]      irq_vector,
  output logic [1:0]            irq_kind,
  output logic [IDX_W-1:0]      irq_idx,
  output logic                  wake
);

  // ---------------- pin edge detectors ----------------
  logic [1:0]         pin_mode [NUM_PIN];
  logic [NUM_PIN-1:0] pin_edge;

  assign pin_mode[0] = pin1_mode;
  assign pin_mode[1] = pin2_mode;
  assign pin_mode[2] = EDGE_FALL;

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    irq_edge_det #(.SYNC_STAGES(2)) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin        (pin_in[p]),
      .mode       (pin_mode[p]),
      .edge_pulse (pin_edge[p])
    );
  end

  // ---------------- request flags ----------------
  logic [NUM_MSK-1:0] flag_set, flag_q, ack_vec;

  assign flag_set = {periph_evt, pin_edge, wdt_evt};

  irq_flag_bank #(.N(NUM_MSK)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (flag_set),
    .sw_clr_i  (req_clr),
    .ack_clr_i (ack_vec),
    .req_o     (flag_q)
  );

  // ---------------- resolver ----------------
  logic             msk_hit, sel_high;
  logic [IDX_W-1:0] sel_idx;

  irq_resolver #(.N(NUM_MSK), .IDX_W(IDX_W)) u_resolve (
    .req      (flag_q),
    .mask     (mask_bits),
    .prio     (prio_bits),
    .hit      (msk_hit),
    .grp_high (sel_high),
    .idx      (sel_idx)
  );

  // ---------------- control state ----------------
  logic ie_q, svc_high_q, nmi_pend_q, nmi_busy_q, brk_pend_q;
  logic take_nmi, take_brk, take_msk, accept;

  assign take_nmi = nmi_pend_q & ~nmi_busy_q;
  assign take_brk = ~take_nmi & brk_pend_q;
  assign take_msk = ~take_nmi & ~brk_pend_q & msk_hit & ie_q & ~svc_high_q;
  assign irq_valid = take_nmi | take_brk | take_msk;
  assign accept    = irq_valid & irq_ack;
  assign ack_vec   = (accept & take_msk) ? (NUM_MSK'(1) << sel_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q       <= 1'b0;
      svc_high_q <= 1'b0;
      nmi_pend_q <= 1'b0;
      nmi_busy_q <= 1'b0;
      brk_pend_q <= 1'b0;
    end else begin
      if (accept)      ie_q <= 1'b0;
      else if (ie_set) ie_q <= 1'b1;

      if (accept & take_msk) svc_high_q <= sel_high;
      else if (reti)         svc_high_q <= 1'b0;

      if (nmi_evt)                nmi_pend_q <= 1'b1;
      else if (accept & take_nmi) nmi_pend_q <= 1'b0;

      if (accept & take_nmi) nmi_busy_q <= 1'b1;
      else if (nmi_ret)      nmi_busy_q <= 1'b0;

      if (brk_req)                brk_pend_q <= 1'b1;
      else if (accept & take_brk) brk_pend_q <= 1'b0;
    end
  end

  // ---------------- outputs ----------------
  always_comb begin
    irq_vector = '0;
    irq_kind   = KIND_NONE;
    irq_idx    = '0;
    if (take_nmi) begin
      irq_vector = NMI_VEC;
      irq_kind   = KIND_NMI;
    end else if (take_brk) begin
      irq_vector = BRK_VEC;
      irq_kind   = KIND_BRK;
    end else if (take_msk) begin
      irq_vector = msk_vector(sel_idx);
      irq_kind   = KIND_MSK;
      irq_idx    = sel_idx;
    end
  end

  assign wake = msk_hit | nmi_pend_q;

  // ---------------- assertions ----------------
  a_r6_enable_drops: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ie_q);

  a_r6_group_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && take_msk && sel_high) |=> svc_high_q);

  a_r7_nmi_not_reentered: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && take_nmi) |=> !(irq_valid && irq_kind == KIND_NMI));

  a_r11_offer_implies_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_kind == KIND_MSK) |-> wake);

  a_r5_offer_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_kind == KIND_MSK) |-> (ie_q && !svc_high_q));

endmodule

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wdt_evt = 1'b0;
  logic [3:0]  periph_evt = '0;
  logic        nmi_evt = 1'b0;
  logic        brk_req = 1'b0;
  logic [2:0]  pin_in = 3'b111;
  logic [1:0]  pin1_mode = 2'b00;
  logic [1:0]  pin2_mode = 2'b00;
  logic [7:0]  mask_bits = '0;
  logic [7:0]  prio_bits = '0;
  logic [7:0]  req_clr = '0;
  logic        ie_set = 1'b0;
  logic        reti = 1'b0;
  logic        nmi_ret = 1'b0;
  logic        irq_ack = 1'b0;
  logic        irq_valid;
  logic [15:0] irq_vector;
  logic [1:0]  irq_kind;
  logic [2:0]  irq_idx;
  logic        wake;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_arbiter dut (
    .clk(clk), .rst_n(rst_n), .wdt_evt(wdt_evt), .periph_evt(periph_evt),
    .nmi_evt(nmi_evt), .brk_req(brk_req), .pin_in(pin_in),
    .pin1_mode(pin1_mode), .pin2_mode(pin2_mode), .mask_bits(mask_bits),
    .prio_bits(prio_bits), .req_clr(req_clr), .ie_set(ie_set), .reti(reti),
    .nmi_ret(nmi_ret), .irq_ack(irq_ack), .irq_valid(irq_valid),
    .irq_vector(irq_vector), .irq_kind(irq_kind), .irq_idx(irq_idx), .wake(wake)
  );

  typedef struct packed {
    logic [7:0]  evt;
    logic [7:0]  mask;
    logic [7:0]  prio;
    logic        exp_v;
    logic [15:0] exp_vec;
  } vec_t;

  localparam vec_t TBL [0:7] = '{
    '{8'h01, 8'h00, 8'h00, 1'b1, 16'h0004},  // R2 watchdog-interval
    '{8'hF0, 8'h00, 8'h00, 1'b1, 16'h0010},  // R3 serial first in order
    '{8'hF0, 8'h00, 8'h80, 1'b1, 16'h001A},  // R4 high group wins
    '{8'hF0, 8'h10, 8'h00, 1'b1, 16'h0016},  // R5 masked serial skipped
    '{8'hC0, 8'h00, 8'hC0, 1'b1, 16'h0018},  // R3 order inside high group
    '{8'h11, 8'h11, 8'h00, 1'b0, 16'h0000},  // R5 all masked
    '{8'hA1, 8'h00, 8'h20, 1'b1, 16'h0016},  // R4 timer 1 high group
    '{8'h80, 8'h00, 8'h00, 1'b1, 16'h001A}   // R2 conversion end
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clean();
    req_clr = '1; reti = 1'b1; nmi_ret = 1'b1;
    step();
    req_clr = '0; reti = 1'b0; nmi_ret = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    step();
    irq_ack = 1'b0;
  endtask

  task automatic enable();
    ie_set = 1'b1;
    step();
    ie_set = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk("R1 valid", 16'(irq_valid), 16'h0);
    chk("R1 wake", 16'(wake), 16'h0);
    chk("R1 vector", irq_vector, 16'h0000);
    chk("R1 kind", 16'(irq_kind), 16'h3);

    // table walk
    for (int i = 0; i < 8; i++) begin
      clean();
      mask_bits = TBL[i].mask;
      prio_bits = TBL[i].prio;
      enable();
      wdt_evt = TBL[i].evt[0];
      periph_evt = TBL[i].evt[7:4];
      step();
      wdt_evt = 1'b0; periph_evt = '0;
      chk("R3/R4/R5 table valid", 16'(irq_valid), 16'(TBL[i].exp_v));
      chk("R11 table wake", 16'(wake), 16'(|(TBL[i].evt & ~TBL[i].mask)));
      if (TBL[i].exp_v) begin
        chk("R2 table vector", irq_vector, TBL[i].exp_vec);
        chk("R2 table kind", 16'(irq_kind), 16'h0);
        ack();
        chk("R6 table enable cleared", 16'(irq_valid), 16'h0);
      end
    end
    clean();
    mask_bits = '0; prio_bits = '0;

    // R5 and R11: pending but disabled
    periph_evt = 4'b0100;
    step();
    periph_evt = '0;
    chk("R5 no offer without enable", 16'(irq_valid), 16'h0);
    chk("R11 wake while disabled", 16'(wake), 16'h1);
    mask_bits = 8'h40;
    step();
    chk("R11 masked no wake", 16'(wake), 16'h0);
    mask_bits = '0;
    enable();
    chk("R2 timer2 vector", irq_vector, 16'h0018);
    chk("R2 timer2 index", 16'(irq_idx), 16'h6);
    ack();
    chk("R6 valid after ack", 16'(irq_valid), 16'h0);
    chk("R6 flag cleared", 16'(wake), 16'h0);

    // R6 in-service group, R12 return
    prio_bits = 8'h20;
    periph_evt = 4'b0010; ie_set = 1'b1;
    step();
    periph_evt = '0; ie_set = 1'b0;
    chk("R4 timer1 vector", irq_vector, 16'h0016);
    ack();
    periph_evt = 4'b1000; ie_set = 1'b1;
    step();
    periph_evt = '0; ie_set = 1'b0;
    chk("R5 low blocked by high service", 16'(irq_valid), 16'h0);
    chk("R11 wake during service", 16'(wake), 16'h1);
    periph_evt = 4'b0010;
    step();
    periph_evt = '0;
    chk("R5 high blocked by high service", 16'(irq_valid), 16'h0);
    req_clr = 8'h20;
    step();
    req_clr = '0;
    reti = 1'b1;
    step();
    reti = 1'b0;
    chk("R12 offer after return", irq_vector, 16'h001A);
    ack();
    clean();
    prio_bits = '0;

    // R7 non-maskable
    mask_bits = '1;
    nmi_evt = 1'b1;
    step();
    nmi_evt = 1'b0;
    chk("R7 nmi kind", 16'(irq_kind), 16'h1);
    chk("R7 nmi vector", irq_vector, 16'h0004);
    ack();
    chk("R7 nmi gone", 16'(irq_valid), 16'h0);
    nmi_evt = 1'b1;
    step();
    nmi_evt = 1'b0;
    chk("R7 no re-entry", 16'(irq_valid), 16'h0);
    chk("R11 nmi wake", 16'(wake), 16'h1);
    nmi_ret = 1'b1;
    step();
    nmi_ret = 1'b0;
    chk("R7 offered after return", 16'(irq_kind), 16'h1);
    ack();
    clean();
    mask_bits = '0;
    chk("R7 idle", 16'(irq_valid), 16'h0);

    // R8 break against non-maskable and maskable
    nmi_evt = 1'b1; brk_req = 1'b1;
    step();
    nmi_evt = 1'b0; brk_req = 1'b0;
    chk("R8 nmi before break", 16'(irq_kind), 16'h1);
    ack();
    chk("R8 break kind", 16'(irq_kind), 16'h2);
    chk("R8 break vector", irq_vector, 16'h003E);
    ack();
    chk("R8 break gone", 16'(irq_valid), 16'h0);
    clean();
    periph_evt = 4'b0001; ie_set = 1'b1; brk_req = 1'b1;
    step();
    periph_evt = '0; ie_set = 1'b0; brk_req = 1'b0;
    chk("R8 break over maskable", 16'(irq_kind), 16'h2);
    ack();
    chk("R6 enable cleared by break", 16'(irq_valid), 16'h0);
    enable();
    chk("R3 serial after break", irq_vector, 16'h0010);
    ack();

    // R10 collisions
    periph_evt = 4'b0001; req_clr = 8'h10;
    step();
    periph_evt = '0; req_clr = '0;
    chk("R10 event beats clear", 16'(wake), 16'h1);
    req_clr = 8'h10;
    step();
    req_clr = '0;
    chk("R10 clear alone", 16'(wake), 16'h0);
    periph_evt = 4'b0001; ie_set = 1'b1;
    step();
    periph_evt = '0; ie_set = 1'b0;
    chk("R10 offer", irq_vector, 16'h0010);
    periph_evt = 4'b0001; irq_ack = 1'b1;
    step();
    periph_evt = '0; irq_ack = 1'b0;
    chk("R10 ack drops offer", 16'(irq_valid), 16'h0);
    chk("R10 event beats ack", 16'(wake), 16'h1);
    enable();
    chk("R10 offered again", irq_vector, 16'h0010);
    ack();
    chk("R10 finally clear", 16'(wake), 16'h0);
    clean();

    // R9 pins
    pin1_mode = 2'b01;
    pin_in[0] = 1'b0;
    repeat (3) step();
    chk("R9 pin1 fall ignored in rise mode", 16'(wake), 16'h0);
    pin_in[0] = 1'b1;
    repeat (2) step();
    chk("R9 sync latency", 16'(wake), 16'h0);
    step();
    chk("R9 pin1 rise seen", 16'(wake), 16'h1);
    enable();
    chk("R2 pin1 vector", irq_vector, 16'h0008);
    ack();

    pin2_mode = 2'b11;
    pin_in[1] = 1'b0;
    repeat (3) step();
    chk("R9 pin2 fall in both mode", 16'(wake), 16'h1);
    enable();
    chk("R2 pin2 vector", irq_vector, 16'h000A);
    ack();
    pin_in[1] = 1'b1;
    repeat (3) step();
    chk("R9 pin2 rise in both mode", 16'(wake), 16'h1);
    req_clr = 8'h04;
    step();
    req_clr = '0;
    chk("R10 pin2 software clear", 16'(wake), 16'h0);

    pin_in[2] = 1'b0;
    repeat (3) step();
    chk("R9 pin3 fall", 16'(wake), 16'h1);
    enable();
    chk("R2 pin3 vector", irq_vector, 16'h000C);
    ack();
    pin_in[2] = 1'b1;
    repeat (3) step();
    chk("R9 pin3 rise ignored", 16'(wake), 16'h0);

    pin2_mode = 2'b00;
    pin_in[1] = 1'b0;
    repeat (3) step();
    chk("R9 pin2 off", 16'(wake), 16'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog R1: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule